// File: doc/BRIEF.md
# Line Burst Transfer Controller

This block is a bus master that moves one 16-byte line, four 32-bit long words, between a requester and a slave on a 32-bit data bus. A request carries an address, a direction and, for writes, the full 128-bit line. The controller first clears the low four address bits and tries a burst: one address phase marked as a line transfer, followed by four data phases, each ended by the slave's acknowledge.

A slave that cannot burst raises its burst-inhibit input together with the acknowledge of the first long word. The controller then finishes the line with three separate single long-word bus cycles, each with its own address phase and its own acknowledge. When the fourth long word has been acknowledged the controller pulses its done output for one clock; on reads the assembled line is on the read-data port by then.

Top module: `lbc_line_xfer`

## Requirements
- R1: After reset, bus_ts, bus_burst, busy and done are 0, and rd_data is all zeros.
- R2: The first address phase of a line drives bus_addr equal to req_addr with its low four bits cleared, bus_size = 2'b11 (line) and bus_burst = 1, for exactly one cycle.
- R3: Without burst-inhibit, a line uses exactly one address phase; the four data phases show bus_addr at line offsets 0, 4, 8 and 12 in that order, with bus_ts low and bus_burst high.
- R4: If bus_inhibit is high with the first acknowledge, the remaining three long words each get a single-cycle address phase with bus_ts = 1, bus_burst = 0, bus_size = 2'b00 (long word) and bus_addr at offsets 4, 8 and 12 in order.
- R5: bus_inhibit is sampled only with the first acknowledge of a line; when it is high with a later acknowledge the transfer stays a burst.
- R6: A data phase ends only on bus_ack; while bus_ack is low, bus_addr is held and bus_ts stays low.
- R7: done is high for exactly one cycle, the cycle after the fourth acknowledge; on reads rd_data then holds the four long words with the word from offset 0 in bits 127:96 and the word from offset 12 in bits 31:0.
- R8: On writes, bus_wdata in the data phase of the word at offset 4*k is req_wdata[127-32*k -: 32] as captured when the request was accepted.
- R9: req_valid is accepted only while busy is 0; a request raised while busy changes neither bus_addr nor the sequence, and starts no further bus cycle.
- R10: bus_write equals the accepted request's req_write for the whole line, from its first address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line request, accepted when idle |
| req_addr | input | 32 | Line address (low four bits ignored) |
| req_write | input | 1 | 1 = write line, 0 = read line |
| req_wdata | input | 128 | Line to write, offset 0 in bits 127:96 |
| busy | output | 1 | Line transfer in progress |
| done | output | 1 | One-cycle pulse after the fourth long word |
| rd_data | output | 128 | Line read, offset 0 in bits 127:96 |
| bus_addr | output | 32 | Bus address |
| bus_size | output | 2 | 2'b11 line, 2'b00 long word |
| bus_burst | output | 1 | Burst (line) transfer in progress |
| bus_ts | output | 1 | Transfer start, one cycle per address phase |
| bus_write | output | 1 | Direction of the current transfer |
| bus_wdata | output | 32 | Write data for the current long word |
| bus_rdata | input | 32 | Read data from the slave |
| bus_ack | input | 1 | Data phase acknowledge |
| bus_inhibit | input | 1 | Burst-inhibit, honoured with the first acknowledge only |

## Verification
On every cycle the assertions check that transfer start and done are single-cycle pulses, that a burst address phase is line-aligned, that single cycles are marked as long words, that the address holds through wait states and advances by four on each acknowledge, and that a late burst-inhibit never diverts a burst. The exact address order, the fallback after a first-word inhibit, the packing of read data, the selection of write words and the refusal of requests while busy depend on the slave's answers over a whole line, so only the bench's scenarios, with and without wait states, show them.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BADDR = 3'd1,
        ST_BDATA = 3'd2,
        ST_SADDR = 3'd3,
        ST_SDATA = 3'd4
    } lbc_state_e;

    localparam logic [1:0] SZ_LONG = 2'b00;
    localparam logic [1:0] SZ_LINE = 2'b11;

endpackage

// File: rtl/lbc_seq.sv
module lbc_seq
    import lbc_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             bus_ack,
    input  logic             bus_inhibit,
    output logic             load,
    output logic             capture,
    output logic [IDX_W-1:0] idx,
    output logic             ts,
    output logic             burst,
    output logic [1:0]       size,
    output logic             busy,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    typedef struct packed {
        lbc_state_e       state;
        logic [IDX_W-1:0] idx;
        logic             done;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        load       = 1'b0;
        capture    = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    load        = 1'b1;
                    seq_d.idx   = '0;
                    seq_d.state = ST_BADDR;
                end
            end
            ST_BADDR: seq_d.state = ST_BDATA;
            ST_BDATA: begin
                if (bus_ack) begin
                    capture = 1'b1;
                    if (seq_q.idx == '0 && bus_inhibit) begin
                        seq_d.idx   = seq_q.idx + 1'b1;
                        seq_d.state = ST_SADDR;
                    end else if (seq_q.idx == LAST) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            ST_SADDR: seq_d.state = ST_SDATA;
            ST_SDATA: begin
                if (bus_ack) begin
                    capture = 1'b1;
                    if (seq_q.idx == LAST) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.idx   = seq_q.idx + 1'b1;
                        seq_d.state = ST_SADDR;
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.idx   <= '0;
            seq_q.done  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idx   = seq_q.idx;
    assign ts    = (seq_q.state == ST_BADDR) || (seq_q.state == ST_SADDR);
    assign burst = (seq_q.state == ST_BADDR) || (seq_q.state == ST_BDATA);
    assign size  = burst ? SZ_LINE : SZ_LONG;
    assign busy  = (seq_q.state != ST_IDLE);
    assign done  = seq_q.done;

    logic in_data;
    assign in_data = (seq_q.state == ST_BDATA) || (seq_q.state == ST_SDATA);

    // R2 / R4: an address phase lasts one cycle
    a_r2_ts_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ts |=> !ts);

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: no acknowledge, no progress
    a_r6_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !bus_ack) |=> (in_data && $stable(idx) && !ts));

    // R5: inhibit after the first word never leaves the burst
    a_r5_late_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_BDATA && bus_ack && idx != '0) |=> (burst || !busy));

    // R4: single cycles are long-word sized
    a_r4_single_size: assert property (@(posedge clk) disable iff (!rst_n)
        (ts && !burst) |-> (size == SZ_LONG));

    // R9: done follows the return to idle
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/lbc_req_latch.sv
module lbc_req_latch #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    localparam int IDX_W      = $clog2(WORDS),
    localparam int WORD_BYTES = WORD_W / 8,
    localparam int WB_W       = $clog2(WORD_BYTES),
    localparam int LINE_BYTES = WORD_BYTES * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write
);

    localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              write;
    } latch_s;

    latch_s lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (load) begin
            lat_d.base  = req_addr & ~LINE_MASK;
            lat_d.write = req_write;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    logic [ADDR_W-1:0] offset;
    assign offset    = ADDR_W'({idx, {WB_W{1'b0}}});
    assign bus_addr  = lat_q.base | offset;
    assign bus_write = lat_q.write;

endmodule

// File: rtl/lbc_word_buf.sv
module lbc_word_buf #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int LINE_W = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LINE_W-1:0] req_wdata,
    input  logic              capture,
    input  logic              is_write,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic [LINE_W-1:0] rd_data,
    output logic [WORD_W-1:0] wr_word
);

    typedef struct packed {
        logic [WORDS-1:0][WORD_W-1:0] w;
    } wbuf_s;

    wbuf_s buf_d, buf_q;
    logic [WORDS-1:0][WORD_W-1:0] req_words;

    // word k of the line sits in the k-th long word from the top
    for (genvar k = 0; k < WORDS; k++) begin : g_map
        assign req_words[k] = req_wdata[LINE_W-1-k*WORD_W -: WORD_W];
        assign rd_data[LINE_W-1-k*WORD_W -: WORD_W] = buf_q.w[k];
    end

    always_comb begin
        buf_d = buf_q;
        if (load) begin
            buf_d.w = req_words;
        end else if (capture && !is_write) begin
            buf_d.w[idx] = bus_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign wr_word = buf_q.w[idx];

endmodule

// File: rtl/lbc_line_xfer.sv
module lbc_line_xfer
    import lbc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    localparam int IDX_W      = $clog2(WORDS),
    localparam int LINE_W     = WORD_W * WORDS,
    localparam int WORD_BYTES = WORD_W / 8,
    localparam int OFF_W      = $clog2(WORD_BYTES * WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [LINE_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [LINE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic              bus_burst,
    output logic              bus_ts,
    output logic              bus_write,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_inhibit
);

    logic             load;
    logic             capture;
    logic [IDX_W-1:0] idx;

    lbc_seq #(.WORDS(WORDS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .bus_ack    (bus_ack),
        .bus_inhibit(bus_inhibit),
        .load       (load),
        .capture    (capture),
        .idx        (idx),
        .ts         (bus_ts),
        .burst      (bus_burst),
        .size       (bus_size),
        .busy       (busy),
        .done       (done)
    );

    lbc_req_latch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .req_addr (req_addr),
        .req_write(req_write),
        .idx      (idx),
        .bus_addr (bus_addr),
        .bus_write(bus_write)
    );

    lbc_word_buf #(.WORD_W(WORD_W), .WORDS(WORDS)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .req_wdata(req_wdata),
        .capture  (capture),
        .is_write (bus_write),
        .idx      (idx),
        .bus_rdata(bus_rdata),
        .rd_data  (rd_data),
        .wr_word  (bus_wdata)
    );

    // R2: a burst address phase is line-aligned
    a_r2_align: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ts && bus_burst) |-> (bus_addr[OFF_W-1:0] == '0));

    // R3: each acknowledged word but the last advances the address by one word
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && idx != IDX_W'(WORDS - 1))
        |=> (bus_addr == $past(bus_addr) + ADDR_W'(WORD_BYTES)));

    // R10: direction is stable while a line is in progress
    a_r10_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bus_write));

endmodule

// File: tb/sim_lbc_line_xfer.sv
module sim_lbc_line_xfer;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         req_write = 1'b0;
    logic [127:0] req_wdata = '0;
    logic         busy, done;
    logic [127:0] rd_data;
    logic [31:0]  bus_addr;
    logic [1:0]   bus_size;
    logic         bus_burst, bus_ts, bus_write;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata = '0;
    logic         bus_ack = 1'b0;
    logic         bus_inhibit = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lbc_line_xfer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_burst(bus_burst), .bus_ts(bus_ts), .bus_write(bus_write),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .bus_inhibit(bus_inhibit)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rpat(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    function automatic logic [31:0] wword(input logic [31:0] a, input int k);
        return a ^ (32'h0101_0101 * 32'(k + 1));
    endfunction

    // one complete line, acting as slave
    task automatic run_line(input logic [31:0] addr, input bit wr, input bit inh,
                            input bit late_inh, input int waits, input bit intrude);
        logic [31:0]  base;
        logic [127:0] wd;
        base = addr & 32'hFFFF_FFF0;
        for (int k = 0; k < 4; k++) wd[127-32*k -: 32] = wword(addr, k);
        req_valid = 1'b1; req_addr = addr; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~addr; req_wdata = ~wd; req_write = ~wr;
        check(bus_ts && bus_burst && bus_size == 2'b11 && bus_addr == base,
              "R2 line address phase", bus_addr, base);
        check(bus_write == wr, "R10 direction", 32'(bus_write), 32'(wr));
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] ea;
            ea = base + 32'(4 * k);
            if (inh && k > 0) begin
                check(bus_ts && !bus_burst && bus_size == 2'b00 && bus_addr == ea,
                      "R4 single address phase", bus_addr, ea);
                @(negedge clk);
            end
            for (int w = 0; w < waits; w++) begin
                if (intrude && k == 1 && w == 0) begin
                    req_valid = 1'b1; req_addr = 32'h0BAD_0000;
                end
                check(!bus_ts && bus_addr == ea, "R6 wait state hold", bus_addr, ea);
                @(negedge clk);
                req_valid = 1'b0;
            end
            if (intrude && k == 1)
                check(bus_addr == ea, "R9 request while busy ignored", bus_addr, ea);
            check(bus_addr == ea && !bus_ts, "R3 data phase address", bus_addr, ea);
            if (!inh || k == 0)
                check(bus_burst, "R3 R5 stays burst", 32'(bus_burst), 32'd1);
            if (wr)
                check(bus_wdata == wword(addr, k), "R8 write word", bus_wdata,
                      wword(addr, k));
            bus_ack = 1'b1; bus_rdata = rpat(ea);
            bus_inhibit = (k == 0) ? inh : late_inh;
            @(negedge clk);
            bus_ack = 1'b0; bus_inhibit = 1'b0; bus_rdata = 32'hDEAD_BEEF;
            if (k < 3)
                check(!done, "R7 no early done", 32'(done), 32'd0);
        end
        check(done && !busy, "R7 done pulse", 32'(done), 32'd1);
        if (!wr)
            for (int k = 0; k < 4; k++)
                check(rd_data[127-32*k -: 32] == rpat(base + 32'(4 * k)),
                      "R7 read packing", rd_data[127-32*k -: 32],
                      rpat(base + 32'(4 * k)));
        @(negedge clk);
        check(!done, "R7 done one cycle", 32'(done), 32'd0);
        check(!bus_ts && !busy, "R9 no extra cycle", 32'(bus_ts), 32'd0);
    endtask

    localparam int NV = 6;
    localparam logic [31:0] V_ADDR [NV] = '{32'h0000_1000, 32'h0000_2037,
        32'h8000_004C, 32'h1234_567F, 32'hFFFF_FFF4, 32'h0000_0008};
    localparam bit V_WR   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam bit V_INH  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam bit V_LATE [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam int V_WAIT [NV] = '{0, 1, 0, 2, 1, 0};

    initial begin
        repeat (3) @(negedge clk);
        check(!bus_ts && !bus_burst && !busy && !done, "R1 reset outputs",
              {28'd0, bus_ts, bus_burst, busy, done}, 32'd0);
        check(rd_data == '0, "R1 reset read data", rd_data[31:0], 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++)
            run_line(V_ADDR[i], V_WR[i], V_INH[i], V_LATE[i], V_WAIT[i], 1'b0);
        // R9: request while busy, burst and fallback
        run_line(32'h0000_4410, 1'b0, 1'b0, 1'b0, 2, 1'b1);
        run_line(32'h0000_5520, 1'b1, 1'b1, 1'b0, 1, 1'b1);
        // R6: acknowledge during an address phase is not a data phase
        req_valid = 1'b1; req_addr = 32'h0000_6600; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        check(bus_addr == 32'h0000_6600 && busy, "R6 ack in address phase ignored",
              bus_addr, 32'h0000_6600);
        for (int k = 0; k < 4; k++) begin
            bus_ack = 1'b1; bus_rdata = 32'(k);
            @(negedge clk);
        end
        bus_ack = 1'b0;
        check(done, "R7 done after address-phase ack test", 32'(done), 32'd1);
        @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule